// File: doc/BRIEF.md
# Multi-Mode Multiply-Accumulate Slice

This block is a pipelined signed arithmetic slice for filter and transform datapaths. One multiply array is split at run time, cycle by cycle, into one 18x36 multiply, two independent 18x18 multiplies or four independent 9x9 multiplies. A fourth mode multiplies two 18x18 pairs and sums them. The wide mode and the summing mode can send their product straight to the output. They can also add it into a wide accumulator, and the width of that accumulator depends on the mode. Saturation and half-up rounding can each be enabled as the value leaves the slice.

Every operation passes through three matched register stages: the operand capture, the product register and the accumulator/output register. All lanes of a mode therefore appear on the output in the same cycle, together with a valid flag. The slice accepts one operation per cycle. A sticky overflow flag records any accumulator overflow until reset.

Top module: `mmac_slice`

## Requirements
- R1: An operation presented with in_valid high appears on result with out_valid high exactly three rising edges later. Operations may be issued on consecutive cycles. When out_valid is low, result holds its previous value.
- R2: Mode 0 (wide) multiplies op_a[17:0] by op_b[35:0], both signed. When acc_en is low, it outputs the 54-bit product sign-extended to 72 bits.
- R3: Mode 1 (pair) runs two independent signed 18x18 multiplies. Lane i takes bits [18i+17:18i] of both operands. The 36-bit product of lane i is placed at result[36i+35:36i].
- R4: Mode 2 (quad) runs four independent signed 9x9 multiplies. Lane i takes bits [9i+8:9i] of both operands. The 18-bit product of lane i is placed at result[18i+17:18i].
- R5: In mode 0 with acc_en high, the product is added to a 54-bit signed accumulator. The new accumulator value is output, sign-extended.
- R6: Mode 3 (pair-sum) forms the sum of the two 18x18 lane products. With acc_en high, the sum is added to a 52-bit accumulator, and the new value is output. The 52-bit accumulator is the low 52 bits of the stored value, read as signed. With acc_en low, the sum is output directly and the accumulator is unchanged.
- R7: With acc_en high, load high replaces the accumulator with the new product or product sum instead of adding to it.
- R8: An accumulate result outside the range of the active width (54 or 52 bits) sets ovf_sticky. With sat_en high, the result is clamped to the most positive or most negative value of that width. With sat_en low, it wraps within that width.
- R9: In modes 0 and 3 with rnd_en high and rnd_pos = k > 0, the output is rounded half-up: 2^(k-1) is added and the bits below k are cleared. The accumulator keeps the unrounded value. Rounding has no effect in modes 1 and 2.
- R10: The accumulator does not change in modes 1 and 2 (acc_en is ignored there), on cycles with in_valid low, or when acc_en is low.
- R11: Synchronous reset clears the accumulator, result, out_valid and ovf_sticky. Only reset clears ovf_sticky.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| mode | input | 2 | 0 wide, 1 pair, 2 quad, 3 pair-sum |
| op_a | input | 36 | Operand A, lanes packed from bit 0 |
| op_b | input | 36 | Operand B, lanes packed from bit 0 |
| acc_en | input | 1 | Accumulate instead of pass-through (modes 0, 3) |
| load | input | 1 | Replace the accumulator instead of adding |
| sat_en | input | 1 | Clamp on overflow instead of wrapping |
| rnd_en | input | 1 | Enable output rounding |
| rnd_pos | input | 7 | Rounding bit position |
| out_valid | output | 1 | Result valid |
| result | output | 72 | Packed products or accumulator value |
| ovf_sticky | output | 1 | Sticky accumulator overflow |

## Verification
The assertions assume that reset is held for at least one edge before use, and that in_valid and the operation fields are stable around the rising edge. The pair-sum range property also relies on the fact that only pair-sum accumulates can leave a value outside the 52-bit range. Inputs are therefore changed only on falling edges, and in_valid stays low throughout reset. The bench changes the operand fields on idle cycles to show that they are ignored. It moves to a 52-bit accumulate only after loading a value whose low 52 bits land exactly on the negative limit, so the clamp is reached in two operations.

// File: rtl/mmac_pkg.sv
package mmac_pkg;
  localparam int RND_W = 7;

  typedef enum logic [1:0] {
    MD_WIDE = 2'd0,
    MD_PAIR = 2'd1,
    MD_QUAD = 2'd2,
    MD_PSUM = 2'd3
  } mode_e;

  typedef struct packed {
    logic             vld;
    mode_e            mode;
    logic             acc_en;
    logic             load;
    logic             sat_en;
    logic             rnd_en;
    logic [RND_W-1:0] rnd_pos;
  } ctl_t;
endpackage

// File: rtl/mmac_lane_mul.sv
module mmac_lane_mul #(
  parameter int W = 19
) (
  input  logic signed [W-1:0]   x,
  input  logic signed [W-1:0]   y,
  output logic signed [2*W-1:0] p
);
  assign p = x * y;
endmodule

// File: rtl/mmac_in_reg.sv
module mmac_in_reg import mmac_pkg::*; #(
  parameter int OP_W = 36
) (
  input  logic            clk,
  input  logic            rst,
  input  ctl_t            ctl_i,
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  output ctl_t            ctl_o,
  output logic [OP_W-1:0] a_o,
  output logic [OP_W-1:0] b_o
);
  always_ff @(posedge clk) begin
    ctl_o <= ctl_i;
    a_o   <= a_i;
    b_o   <= b_i;
    if (rst) ctl_o.vld <= 1'b0;
  end
endmodule

// File: rtl/mmac_mul_array.sv
module mmac_mul_array import mmac_pkg::*; #(
  parameter int LANE_W = 18
) (
  input  logic                         clk,
  input  logic                         rst,
  input  ctl_t                         ctl_i,
  input  logic [2*LANE_W-1:0]          a_i,
  input  logic [2*LANE_W-1:0]          b_i,
  output ctl_t                         ctl_o,
  output logic [1:0][2*LANE_W+1:0]     pp_o,
  output logic [3:0][LANE_W-1:0]       qp_o
);
  localparam int MW   = LANE_W + 1;
  localparam int PP_W = 2 * MW;
  localparam int HW   = LANE_W / 2;

  logic [1:0][PP_W-1:0]   pp_n;
  logic [3:0][LANE_W-1:0] qp_n;
  logic                   wide;

  assign wide = (ctl_i.mode == MD_WIDE);

  // Two shared 19x19 lanes: in wide mode the low lane treats the low half
  // of B as unsigned and both lanes use the same A half.
  for (genvar i = 0; i < 2; i++) begin : g_lane
    logic signed [MW-1:0]   x;
    logic signed [MW-1:0]   y;
    logic signed [PP_W-1:0] p;
    if (i == 0) begin : g_lo
      always_comb begin
        x = MW'($signed(a_i[LANE_W-1:0]));
        if (wide) y = {1'b0, b_i[LANE_W-1:0]};
        else      y = MW'($signed(b_i[LANE_W-1:0]));
      end
    end else begin : g_hi
      always_comb begin
        if (wide) x = MW'($signed(a_i[LANE_W-1:0]));
        else      x = MW'($signed(a_i[2*LANE_W-1:LANE_W]));
        y = MW'($signed(b_i[2*LANE_W-1:LANE_W]));
      end
    end
    mmac_lane_mul #(.W(MW)) mul_i (.x(x), .y(y), .p(p));
    assign pp_n[i] = p;
  end

  for (genvar q = 0; q < 4; q++) begin : g_quad
    logic signed [HW-1:0]     xa;
    logic signed [HW-1:0]     yb;
    logic signed [LANE_W-1:0] pq;
    assign xa = a_i[q*HW +: HW];
    assign yb = b_i[q*HW +: HW];
    assign pq = xa * yb;
    assign qp_n[q] = pq;
  end

  always_ff @(posedge clk) begin
    ctl_o <= ctl_i;
    pp_o  <= pp_n;
    qp_o  <= qp_n;
    if (rst) ctl_o.vld <= 1'b0;
  end
endmodule

// File: rtl/mmac_acc_stage.sv
module mmac_acc_stage import mmac_pkg::*; #(
  parameter int LANE_W = 18
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctl_t                     ctl_i,
  input  logic [1:0][2*LANE_W+1:0] pp_i,
  input  logic [3:0][LANE_W-1:0]   qp_i,
  output logic                     out_valid,
  output logic [4*LANE_W-1:0]      result,
  output logic                     ovf_sticky,
  output logic [3*LANE_W-1:0]      acc_o
);
  localparam int ACC_W  = 3 * LANE_W;
  localparam int SACC_W = ACC_W - 2;
  localparam int EXT_W  = ACC_W + 2;
  localparam int RES_W  = 4 * LANE_W;
  localparam int PP_W   = 2 * LANE_W + 2;
  localparam int PAIR_W = 2 * LANE_W;
  localparam logic signed [EXT_W-1:0] ONE_X   = EXT_W'(1);
  localparam logic signed [EXT_W-1:0] WIDE_HI = (ONE_X <<< (ACC_W - 1)) - ONE_X;
  localparam logic signed [EXT_W-1:0] WIDE_LO = -(ONE_X <<< (ACC_W - 1));
  localparam logic signed [EXT_W-1:0] SUM_HI  = (ONE_X <<< (SACC_W - 1)) - ONE_X;
  localparam logic signed [EXT_W-1:0] SUM_LO  = -(ONE_X <<< (SACC_W - 1));

  logic signed [PP_W-1:0]  pp0, pp1;
  logic signed [EXT_W-1:0] wide_p, sum_p, prod_x, acc_x, raw, wrap_x;
  logic signed [EXT_W-1:0] hi_lim, lo_lim, fin, val;
  logic signed [RES_W-1:0] val_r;
  logic [RES_W-1:0]        half, mask, res_n;
  logic                    psum, acc_mode, over_hi, over_lo, accum_go;
  logic [ACC_W-1:0]        acc_q;

  assign pp0 = pp_i[0];
  assign pp1 = pp_i[1];

  always_comb begin
    psum     = (ctl_i.mode == MD_PSUM);
    acc_mode = psum || (ctl_i.mode == MD_WIDE);
    wide_p   = EXT_W'(pp0) + (EXT_W'(pp1) <<< LANE_W);
    sum_p    = EXT_W'(pp0) + EXT_W'(pp1);
    prod_x   = psum ? sum_p : wide_p;
    acc_x    = psum ? EXT_W'($signed(acc_q[SACC_W-1:0])) : EXT_W'($signed(acc_q));
    raw      = ctl_i.load ? prod_x : (acc_x + prod_x);
    hi_lim   = psum ? SUM_HI : WIDE_HI;
    lo_lim   = psum ? SUM_LO : WIDE_LO;
    over_hi  = raw > hi_lim;
    over_lo  = raw < lo_lim;
    wrap_x   = psum ? EXT_W'($signed(raw[SACC_W-1:0])) : EXT_W'($signed(raw[ACC_W-1:0]));
    if (!(over_hi || over_lo)) fin = raw;
    else if (ctl_i.sat_en)     fin = over_hi ? hi_lim : lo_lim;
    else                       fin = wrap_x;
    accum_go = ctl_i.vld && acc_mode && ctl_i.acc_en;
    val      = ctl_i.acc_en ? fin : prod_x;

    // Half-up rounding on the output copy only.
    val_r = RES_W'(val);
    if (ctl_i.rnd_en && (ctl_i.rnd_pos != '0)) begin
      half  = RES_W'(1) << (ctl_i.rnd_pos - 1'b1);
      mask  = ~((RES_W'(1) << ctl_i.rnd_pos) - RES_W'(1));
      val_r = $signed((val_r + half) & mask);
    end else begin
      half = '0;
      mask = '1;
    end

    unique case (ctl_i.mode)
      MD_PAIR: res_n = {pp1[PAIR_W-1:0], pp0[PAIR_W-1:0]};
      MD_QUAD: res_n = qp_i;
      default: res_n = val_r;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      result     <= '0;
      acc_q      <= '0;
      ovf_sticky <= 1'b0;
    end else begin
      out_valid <= ctl_i.vld;
      if (ctl_i.vld) result <= res_n;
      if (accum_go) begin
        acc_q <= fin[ACC_W-1:0];
        if (over_hi || over_lo) ovf_sticky <= 1'b1;
      end
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/mmac_slice.sv
module mmac_slice import mmac_pkg::*; #(
  parameter int LANE_W = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [1:0]           mode,
  input  logic [2*LANE_W-1:0]  op_a,
  input  logic [2*LANE_W-1:0]  op_b,
  input  logic                 acc_en,
  input  logic                 load,
  input  logic                 sat_en,
  input  logic                 rnd_en,
  input  logic [RND_W-1:0]     rnd_pos,
  output logic                 out_valid,
  output logic [4*LANE_W-1:0]  result,
  output logic                 ovf_sticky
);
  localparam int OP_W = 2 * LANE_W;

  ctl_t                     ctl_in, ctl_s1, ctl_s2;
  logic [OP_W-1:0]          a_s1, b_s1;
  logic [1:0][OP_W+1:0]     pp_s2;
  logic [3:0][LANE_W-1:0]   qp_s2;
  logic [3*LANE_W-1:0]      acc_val;
  logic                     s2_vld, s2_acc_en;
  logic [1:0]               s2_mode;

  always_comb begin
    ctl_in.vld     = in_valid;
    ctl_in.mode    = mode_e'(mode);
    ctl_in.acc_en  = acc_en;
    ctl_in.load    = load;
    ctl_in.sat_en  = sat_en;
    ctl_in.rnd_en  = rnd_en;
    ctl_in.rnd_pos = rnd_pos;
  end

  mmac_in_reg #(.OP_W(OP_W)) in_i (
    .clk(clk), .rst(rst), .ctl_i(ctl_in), .a_i(op_a), .b_i(op_b),
    .ctl_o(ctl_s1), .a_o(a_s1), .b_o(b_s1)
  );

  mmac_mul_array #(.LANE_W(LANE_W)) mul_i (
    .clk(clk), .rst(rst), .ctl_i(ctl_s1), .a_i(a_s1), .b_i(b_s1),
    .ctl_o(ctl_s2), .pp_o(pp_s2), .qp_o(qp_s2)
  );

  mmac_acc_stage #(.LANE_W(LANE_W)) acc_i (
    .clk(clk), .rst(rst), .ctl_i(ctl_s2), .pp_i(pp_s2), .qp_i(qp_s2),
    .out_valid(out_valid), .result(result), .ovf_sticky(ovf_sticky),
    .acc_o(acc_val)
  );

  assign s2_vld    = ctl_s2.vld;
  assign s2_acc_en = ctl_s2.acc_en;
  assign s2_mode   = ctl_s2.mode;
endmodule

// File: rtl/mmac_slice_chk.sv
module mmac_slice_chk import mmac_pkg::*; #(
  parameter int LANE_W = 18
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                out_valid,
  input logic [4*LANE_W-1:0] result,
  input logic                ovf_sticky,
  input logic                s2_vld,
  input logic                s2_acc_en,
  input logic [1:0]          s2_mode,
  input logic [3*LANE_W-1:0] acc_val
);
  localparam int ACC_W  = 3 * LANE_W;
  localparam int SACC_W = ACC_W - 2;

  logic [2:0] vhist;
  logic [ACC_W-SACC_W:0] top_bits;

  always_ff @(posedge clk) begin
    if (rst) vhist <= '0;
    else     vhist <= {vhist[1:0], in_valid};
  end

  assign top_bits = acc_val[ACC_W-1:SACC_W-1];

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid == vhist[2]);  // R1

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(result));  // R1

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$fell(ovf_sticky));  // R11

  AST_ACC_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    (!s2_vld || !s2_acc_en || s2_mode == 2'(MD_PAIR) || s2_mode == 2'(MD_QUAD))
      |=> $stable(acc_val));  // R10

  AST_PSUM_RANGE: assert property (@(posedge clk) disable iff (rst)
    (s2_vld && s2_acc_en && s2_mode == 2'(MD_PSUM))
      |=> ((&top_bits) || !(|top_bits)));  // R6
endmodule

bind mmac_slice mmac_slice_chk #(.LANE_W(LANE_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .result(result), .ovf_sticky(ovf_sticky), .s2_vld(s2_vld),
  .s2_acc_en(s2_acc_en), .s2_mode(s2_mode), .acc_val(acc_val)
);

// File: tb/mmac_slice_tb.sv
`timescale 1ns/1ps
module mmac_slice_tb_top;
  import mmac_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = '0;
  logic [35:0] op_a = '0, op_b = '0;
  logic        acc_en = 1'b0, load = 1'b0, sat_en = 1'b0, rnd_en = 1'b0;
  logic [6:0]  rnd_pos = '0;
  logic        out_valid, ovf_sticky;
  logic [71:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  mmac_slice dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .op_a(op_a),
    .op_b(op_b), .acc_en(acc_en), .load(load), .sat_en(sat_en),
    .rnd_en(rnd_en), .rnd_pos(rnd_pos), .out_valid(out_valid),
    .result(result), .ovf_sticky(ovf_sticky)
  );

  localparam logic signed [71:0] P52  = 72'sd1 <<< 52;
  localparam logic signed [71:0] P51  = 72'sd1 <<< 51;
  localparam logic [35:0]        AMIN = 36'(-131072);
  localparam logic [35:0]        BMIN = 36'h8_0000_0000;

  typedef struct packed {
    logic [7:0]  req;
    logic [1:0]  md;
    logic        acc;
    logic        ld;
    logic        sat;
    logic        rnd;
    logic [6:0]  pos;
    logic [35:0] a;
    logic [35:0] b;
    logic [71:0] exp;
    logic        eovf;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{8'd2,  2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0, 36'(-3), 36'(1000), 72'(-3000), 1'b0},   // R2
    '{8'd2,  2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0, AMIN, BMIN, P52, 1'b0},                  // R2
    '{8'd3,  2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0, {18'(-5), 18'(7)}, {18'(300), 18'(-2)},
      {36'(-1500), 36'(-14)}, 1'b0},                                                      // R3
    '{8'd4,  2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0, {9'(-1), 9'(2), 9'(-256), 9'(100)},
      {9'(5), 9'(-7), 9'(-256), 9'(3)}, {18'(-5), 18'(-14), 18'(65536), 18'(300)}, 1'b0}, // R4
    '{8'd7,  2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 7'd0, 36'(10), 36'(20), 72'(200), 1'b0},       // R7
    '{8'd5,  2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 7'd0, 36'(-3), 36'(50), 72'(50), 1'b0},        // R5
    '{8'd10, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 7'd0, {18'(1), 18'(1)}, {18'(2), 18'(3)},
      {36'(2), 36'(3)}, 1'b0},                                                            // R10
    '{8'd10, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 7'd0, 36'(1), 36'(1), 72'(51), 1'b0},          // R10
    '{8'd6,  2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 7'd0, {18'(100), 18'(-4)}, {18'(6), 18'(25)},
      72'(500), 1'b0},                                                                    // R6
    '{8'd6,  2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 7'd0, {18'(2), 18'(3)}, {18'(4), 18'(5)},
      72'(523), 1'b0},                                                                    // R6
    '{8'd6,  2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0, {18'(-1), 18'(1)}, {18'(1), 18'(1)},
      72'(0), 1'b0},                                                                      // R6
    '{8'd10, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 7'd0, {18'(0), 18'(1)}, {18'(0), 18'(1)},
      72'(524), 1'b0},                                                                    // R10
    '{8'd9,  2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 7'd4, 36'(1), 36'(4660), 72'(4656), 1'b0},     // R9
    '{8'd9,  2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 7'd4, 36'(-1), 36'(25), 72'(-32), 1'b0},       // R9
    '{8'd9,  2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 7'd4, 36'(1), 36'(24), 72'(32), 1'b0},         // R9
    '{8'd9,  2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 7'd0, 36'(1), 36'(1), 72'(25), 1'b0},          // R9
    '{8'd7,  2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 7'd0, AMIN, BMIN, P52, 1'b0},                  // R7
    '{8'd8,  2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 7'd0, AMIN, BMIN, (P52 <<< 1) - 72'sd1, 1'b1}, // R8
    '{8'd8,  2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 7'd0, AMIN, BMIN, -P52 - 72'sd1, 1'b1},        // R8
    '{8'd9,  2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 7'd4, {27'(0), 9'(1)}, {27'(0), 9'(7)},
      72'(7), 1'b1}                                                                       // R9
  };

  task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic put(input logic [1:0] m, input logic ae, input logic ld,
                     input logic st, input logic rn, input logic [6:0] ps,
                     input logic [35:0] a, input logic [35:0] b);
    in_valid = 1'b1; mode = m; acc_en = ae; load = ld; sat_en = st;
    rnd_en = rn; rnd_pos = ps; op_a = a; op_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run1(input string tag, input logic [1:0] m, input logic ae,
                      input logic ld, input logic st, input logic rn,
                      input logic [6:0] ps, input logic [35:0] a,
                      input logic [35:0] b, input logic [71:0] exp,
                      input logic eovf);
    put(m, ae, ld, st, rn, ps, a, b);
    @(negedge clk);
    @(negedge clk);
    check({tag, " out_valid"}, 72'(out_valid), 72'(1));
    check({tag, " result"}, result, exp);
    check({tag, " ovf"}, 72'(ovf_sticky), 72'(eovf));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R11 reset result", result, '0);
    check("R11 reset valid", 72'(out_valid), 72'(0));
    check("R11 reset ovf", 72'(ovf_sticky), 72'(0));

    for (int i = 0; i < NV; i++) begin
      run1($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].md, VECS[i].acc,
           VECS[i].ld, VECS[i].sat, VECS[i].rnd, VECS[i].pos, VECS[i].a,
           VECS[i].b, VECS[i].exp, VECS[i].eovf);
    end

    // R11: reset clears the sticky flag and accumulator
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R11 post-reset ovf", 72'(ovf_sticky), 72'(0));
    check("R11 post-reset result", result, '0);
    run1("R11 acc cleared", 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 7'd0, 36'(1), 36'(5), 72'(5), 1'b0);

    // R10: idle cycles with changing fields leave everything untouched
    mode = 2'd0; acc_en = 1'b1; load = 1'b1; op_a = 36'(77); op_b = 36'(99);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R10 idle valid", 72'(out_valid), 72'(0));
      check("R10 idle result", result, 72'(5));
    end
    run1("R10 acc kept", 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 7'd0, 36'(1), 36'(1), 72'(6), 1'b0);

    // R8: 52-bit accumulate clamps at the negative limit
    run1("R8 load 2^51", 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 7'd0, AMIN, 36'hC_0000_0000, P51, 1'b0);
    run1("R8 psum clamp", 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 7'd0, {18'(0), 18'(-1)},
         {18'(0), 18'(1)}, -P51, 1'b1);

    // R1: back-to-back issue
    put(2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 7'd0, 36'(1), 36'(1));
    put(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 7'd0, 36'(1), 36'(2));
    put(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 7'd0, 36'(1), 36'(3));
    check("R1 b2b valid0", 72'(out_valid), 72'(1));
    check("R1 b2b res0", result, 72'(1));
    @(negedge clk);
    check("R1 b2b valid1", 72'(out_valid), 72'(1));
    check("R1 b2b res1", result, 72'(3));
    @(negedge clk);
    check("R1 b2b valid2", 72'(out_valid), 72'(1));
    check("R1 b2b res2", result, 72'(6));
    @(negedge clk);
    check("R1 b2b drop", 72'(out_valid), 72'(0));
    check("R1 b2b hold", result, 72'(6));

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule